// File: doc/BRIEF.md
# PCM Voice Serial Port

This block carries one voice sample per frame in each direction between a parallel codec core and a serial time-slot bus. The bus is timed by a master bit clock (MCLK) and an 8 kHz frame strobe (FS). At the start of each slot the port copies a byte from a transmit holding register into a shifter. It then drives that byte MSB first on a serial output that is only enabled inside the slot. In parallel it collects eight serial receive bits into a parallel byte and flags it with a one-cycle strobe.

A two-bit format input picks one of three frame-strobe conventions. In the two non-delayed formats the slot begins in the MCLK period in which the strobe is first seen high. In the delayed format the slot begins one MCLK period later. Reverse format swaps the clock edges used to launch and capture data.

The port runs on a fast system clock. MCLK and FS are inputs sampled on that clock, and each MCLK edge is found by comparing the current sample with the previous one. A frame may hold any number of MCLK periods, for example 64, 192, 256 or 320. The port only reacts to the strobe edge.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is asserted and right after it, `dx_oe` and `rx_valid` are 0 and `rx_byte` is 0.
- R2: Format code 00 (non-delayed normal): the first slot bit is launched on the MCLK launch edge at which FS is sampled high after being low. Eight bits follow MSB first, one per MCLK period.
- R3: Format code 01 (delayed): a rising FS only arms the port. The first bit is launched on the next launch edge, one MCLK period later.
- R4: In codes 00, 01 and 11, transmit bits change after a rising MCLK edge and receive bits are sampled on a falling edge. Code 11 behaves like 00. In code 10 (reverse), transmit changes after a falling edge and receive samples on a rising edge.
- R5: `dx_oe` is high for exactly the eight MCLK periods of the slot and low at all other times. `dx` and `dx_oe` change only in the system-clock cycle after a launch edge.
- R6: Receive bits are taken MSB first on the eight capture edges of the slot. After the eighth capture, `rx_byte` updates and `rx_valid` pulses for one system-clock cycle. At all other times `rx_byte` holds its value.
- R7: A `tx_load` pulse stores `tx_byte` in a holding register. The holding register is copied into the shifter at slot start, so a load during a slot changes only the next slot.
- R8: An FS rise that arrives while a slot is in progress, or while the delayed format is armed, is ignored.
- R9: When a frame carries no FS rise, no slot starts: `dx_oe` stays low and `rx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; MCLK and FS are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk | input | 1 | Serial bit clock, synchronous to clk |
| fs | input | 1 | Frame strobe |
| fmt | input | 2 | Frame-strobe format: 00 normal, 01 delayed, 10 reverse, 11 as normal |
| dr | input | 1 | Serial receive data |
| tx_byte | input | W | Next transmit sample |
| tx_load | input | 1 | Stores tx_byte in the holding register |
| dx | output | 1 | Serial transmit data, valid while dx_oe is high |
| dx_oe | output | 1 | Output enable for the tri-state transmit pad |
| rx_byte | output | W | Last received sample |
| rx_valid | output | 1 | One-cycle strobe when rx_byte updates |

## Verification
Frames are run in each of the four format codes with random transmit and receive bytes. Misplaced slots, wrong bit order and wrong edge polarity therefore all appear as byte or enable-window mismatches. The receive line is driven shortly after the launch edge and corrupted shortly after the capture edge, so sampling on the wrong edge is caught. Directed frames omit the strobe, add a second strobe inside the slot, and reload the holding register in mid-slot. These separate the correct port from one that restarts, keeps driving the line, or forwards a load straight into the shifter.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic [1:0] {
        FMT_NORM = 2'b00,
        FMT_DLY  = 2'b01,
        FMT_REV  = 2'b10,
        FMT_ALT  = 2'b11
    } fmt_e;
endpackage

// File: rtl/pcm_edge_sel.sv
// Finds MCLK edges on the system clock and maps them to launch/capture.
module pcm_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk,
    input  logic swap,
    output logic launch,
    output logic capture
);
    logic mclk_d, mclk_q;
    logic rise, fall;

    always_comb begin
        mclk_d  = mclk;
        rise    = mclk & ~mclk_q;
        fall    = ~mclk & mclk_q;
        launch  = swap ? fall : rise;
        capture = swap ? rise : fall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mclk_q <= 1'b0;
        else        mclk_q <= mclk_d;
    end
endmodule

// File: rtl/pcm_tx_path.sv
// Holding register plus MSB-first shifter.
module pcm_tx_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         start,
    input  logic         shift,
    output logic         bit_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] sh;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)      st_d.sh = st_q.hold;
        else if (shift) st_d.sh = {st_q.sh[W-2:0], 1'b0};
        if (load)       st_d.hold = din;
        bit_o = st_q.sh[W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcm_rx_path.sv
// Collects W bits MSB first on capture edges, then strobes the byte out.
module pcm_rx_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         start,
    input  logic         din,
    output logic [W-1:0] data_o,
    output logic         valid_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic          busy;
        logic [W-1:0]  data;
        logic          valid;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (capture && st_q.busy) begin
            st_d.sh = {st_q.sh[W-2:0], din};
            if (st_q.cnt == LAST) begin
                st_d.busy  = 1'b0;
                st_d.data  = {st_q.sh[W-2:0], din};
                st_d.valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        data_o  = st_q.data;
        valid_o = st_q.valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcm_voice_port.sv
// Slot controller: frame-strobe detection, format handling, slot timing.
module pcm_voice_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mclk,
    input  logic         fs,
    input  logic [1:0]   fmt,
    input  logic         dr,
    input  logic [W-1:0] tx_byte,
    input  logic         tx_load,
    output logic         dx,
    output logic         dx_oe,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid
);
    import pcm_port_pkg::*;

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          fs_prev;
        logic          armed;
        logic          active;
        logic [CW-1:0] bitcnt;
    } slot_st_t;

    slot_st_t st_d, st_q;
    fmt_e     fmt_sel;
    logic     launch, capture;
    logic     start, shift, tx_bit;
    logic     is_dly, fs_rise, free;

    assign fmt_sel = fmt_e'(fmt);

    pcm_edge_sel u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .mclk    (mclk),
        .swap    (fmt_sel == FMT_REV),
        .launch  (launch),
        .capture (capture)
    );

    always_comb begin
        st_d    = st_q;
        start   = 1'b0;
        shift   = 1'b0;
        is_dly  = (fmt_sel == FMT_DLY);
        fs_rise = fs & ~st_q.fs_prev;
        free    = !st_q.active || (st_q.bitcnt == LAST);
        if (launch) begin
            st_d.fs_prev = fs;
            if (st_q.active) begin
                if (st_q.bitcnt == LAST) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.bitcnt = st_q.bitcnt + CW'(1);
                    shift       = 1'b1;
                end
            end
            if (free) begin
                if (is_dly) begin
                    if (st_q.armed) begin
                        start      = 1'b1;
                        st_d.armed = 1'b0;
                    end else if (fs_rise) begin
                        st_d.armed = 1'b1;
                    end
                end else if (fs_rise) begin
                    start = 1'b1;
                end
            end
            if (start) begin
                st_d.active = 1'b1;
                st_d.bitcnt = '0;
            end
        end
        if (!is_dly) st_d.armed = 1'b0;
        dx_oe = st_q.active;
        dx    = st_q.active & tx_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pcm_tx_path #(.W(W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_load),
        .din   (tx_byte),
        .start (start),
        .shift (shift),
        .bit_o (tx_bit)
    );

    pcm_rx_path #(.W(W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .start   (start),
        .din     (dr),
        .data_o  (rx_byte),
        .valid_o (rx_valid)
    );
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         launch,
    input logic         capture,
    input logic         dx,
    input logic         dx_oe,
    input logic [W-1:0] rx_byte,
    input logic         rx_valid
);
    localparam int NW = $clog2(W + 2) + 1;
    logic [NW-1:0] oe_launches;

    always_ff @(posedge clk) begin
        if (!rst_n || !dx_oe) oe_launches <= '0;
        else if (launch)      oe_launches <= oe_launches + NW'(1);
    end

    // R5
    dx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(dx) && $stable(dx_oe)));
    // R5
    slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dx_oe |-> (oe_launches < NW'(W)));
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R6
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(capture));
    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));
endmodule

bind pcm_voice_port pcm_voice_port_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .capture  (capture),
    .dx       (dx),
    .dx_oe    (dx_oe),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid)
);

// File: tb/tb_pcm_voice_port.sv
module tb_pcm_voice_port;
    localparam int FRAME = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk = 1'b0;
    logic       fs = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic       dr = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load = 1'b0;
    logic       dx, dx_oe, rx_valid;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [7:0] vlast = 8'h00;

    always #4 clk = ~clk;

    pcm_voice_port #(.W(8)) dut (
        .clk(clk), .rst_n(rst_n), .mclk(mclk), .fs(fs), .fmt(fmt), .dr(dr),
        .tx_byte(tx_byte), .tx_load(tx_load), .dx(dx), .dx_oe(dx_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcount <= vcount + 1;
            vlast  <= rx_byte;
        end
    end

    function automatic logic launch_level(input logic [1:0] f);
        return (f == 2'b10) ? 1'b0 : 1'b1;
    endfunction

    function automatic int slot_start(input logic [1:0] f);
        return (f == 2'b01) ? 1 : 0;
    endfunction

    function automatic string fmt_tag(input logic [1:0] f);
        if (f == 2'b01) return "R3";
        if (f == 2'b10 || f == 2'b11) return "R4";
        return "R2";
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_tx(input logic [7:0] v);
        @(negedge clk);
        tx_byte = v;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic run_frame(input logic [1:0] f, input logic [7:0] txexp,
                             input logic [7:0] rxv, input bit fs_on,
                             input bit extra, input bit midload,
                             input logic [7:0] newv);
        logic       lv;
        int         s;
        int         oe_bad;
        int         v0;
        logic [7:0] got;
        bit         exp_oe;
        string      dtag;
        lv     = launch_level(f);
        s      = slot_start(f);
        oe_bad = 0;
        got    = 8'h00;
        fmt    = f;
        if (mclk == lv) begin
            @(negedge clk); mclk = ~lv;
            @(negedge clk);
        end
        v0 = vcount;
        for (int p = 0; p < FRAME; p++) begin
            @(negedge clk);
            mclk = lv;
            fs   = fs_on && (p == 0 || (extra && p == 3));
            @(negedge clk);
            if (p >= s && p < s + 8) dr = rxv[7 - (p - s)];
            else                     dr = 1'($urandom);
            if (midload && p == s + 2) begin
                tx_byte = newv;
                tx_load = 1'b1;
            end
            @(negedge clk);
            tx_load = 1'b0;
            exp_oe  = fs_on && p >= s && p < s + 8;
            if (dx_oe !== exp_oe) oe_bad++;
            if (p >= s && p < s + 8) got[7 - (p - s)] = dx;
            mclk = ~lv;
            @(negedge clk);
            dr = 1'($urandom);
        end
        @(negedge clk);
        dtag = extra ? "R8" : (midload ? "R7" : fmt_tag(f));
        if (fs_on) begin
            chk("R5", "enable window mismatches", oe_bad, 0);
            chk(dtag, "transmitted byte", {24'h0, got}, {24'h0, txexp});
            chk("R6", "valid pulses in frame", vcount - v0, 1);
            chk("R6", "received byte", {24'h0, vlast}, {24'h0, rxv});
        end else begin
            chk("R9", "enable high without strobe", oe_bad, 0);
            chk("R9", "valid pulses without strobe", vcount - v0, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a, b;
        logic [1:0] f;
        void'($urandom(32'h5EED1234));
        repeat (4) @(negedge clk);
        // R1: reset values
        chk("R1", "dx_oe in reset", dx_oe, 0);
        chk("R1", "rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "dx_oe after reset", dx_oe, 0);
        chk("R1", "rx_byte after reset", rx_byte, 0);

        load_tx(8'hA5); run_frame(2'b00, 8'hA5, 8'h3C, 1, 0, 0, 8'h00);
        load_tx(8'h81); run_frame(2'b01, 8'h81, 8'hC6, 1, 0, 0, 8'h00);
        load_tx(8'h7E); run_frame(2'b10, 8'h7E, 8'h01, 1, 0, 0, 8'h00);
        load_tx(8'h11); run_frame(2'b11, 8'h11, 8'h80, 1, 0, 0, 8'h00);
        // R9: frame with no strobe
        run_frame(2'b00, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        run_frame(2'b01, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        // R8: second strobe inside the slot
        load_tx(8'hC3); run_frame(2'b00, 8'hC3, 8'h5A, 1, 1, 0, 8'h00);
        load_tx(8'hF0); run_frame(2'b01, 8'hF0, 8'h0F, 1, 1, 0, 8'h00);
        load_tx(8'h96); run_frame(2'b10, 8'h96, 8'h69, 1, 1, 0, 8'h00);
        // R7: load in mid-slot, then the next slot carries the new byte
        load_tx(8'h12); run_frame(2'b00, 8'h12, 8'h34, 1, 0, 1, 8'hEE);
        run_frame(2'b00, 8'hEE, 8'hB7, 1, 0, 0, 8'h00);
        run_frame(2'b10, 8'hEE, 8'h4D, 1, 0, 0, 8'h00);

        for (int i = 0; i < 20; i++) begin
            f = 2'($urandom);
            a = 8'($urandom);
            b = 8'($urandom);
            load_tx(a);
            run_frame(f, a, b, 1, 0, 0, 8'h00);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule